// File: doc/BRIEF.md
# Bidirectional Port Controller with Change Interrupt

This block manages an eight-bit general-purpose I/O port for a small embedded core. Each pin has a direction bit and an output data bit. A global control bit gates a weak pull-up on every pin that is configured as an input. Software reaches the port through a small register bus with four selections:

| Selection | `bus_addr` |
|---|---|
| port data | 0 |
| direction | 1 |
| control/status | 2 |
| single-bit port update | 3 |

Reading the port data returns the live, synchronized pin levels. Writes land only in the output data latch.

The upper four pins can raise a change interrupt. A pin takes part only while it is an input. The pins are compared against a snapshot that is refreshed on every port access, not against their level one clock earlier. A three-state machine tracks the flag:

- `CHG_CLEAR`: the flag is off.
- `CHG_ACTIVE`: the flag is on and a mismatch is present.
- `CHG_HELD`: the flag is on and no mismatch remains.

The transitions are as follows:

- **CLEAR→ACTIVE**: a mismatch appears with no port access in that cycle.
- **ACTIVE→HELD**: a port access occurs, or the mismatch goes away.
- **HELD→ACTIVE**: a new mismatch appears.
- **HELD→CLEAR**: a clear request arrives while no mismatch is present.

A port access always keeps the machine in CLEAR or HELD. A clear request in ACTIVE is ignored.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset every direction bit is 1, `pin_oe` is 0x00, `pin_out` is 0x00, `pin_pull_en` is 0x00, the control read (`bus_addr`=2) returns 0x80, and `chg_irq` is 0.
- R2: A direction bit of 0 drives `pin_oe` high for that pin, and `pin_out` shows the latch bit. A direction bit of 1 drives `pin_oe` low.
- R3: A read with `bus_addr`=0 returns `pin_in` after two clock stages of synchronization, not the output latch.
- R4: A write with `bus_addr`=0 stores `bus_wdata` in the output latch only, and the direction register is unchanged.
- R5: A write with `bus_addr`=3 loads the latch with the synchronized pin levels, with the bit indexed by `bus_wdata[2:0]` replaced by `bus_wdata[3]`.
- R6: Control read bit 0 is the change flag. It is set when a synchronized `pin_in[7:4]` bit whose direction bit is 1 differs from the snapshot. Bits 3:0 and output pins never set it.
- R7: Writing the control register with `bus_wdata[0]`=0 clears the flag, except while a mismatch persists. A port access (read or write at `bus_addr` 0 or 3) captures a new snapshot, and after that the clear takes effect.
- R8: A mismatch that first appears in the cycle in which a port access captures the snapshot is absorbed into the snapshot and does not set the flag.
- R9: `pin_pull_en[i]` is 1 exactly when control bit 7 (pull-up disable) is 0 and direction bit i is 1.
- R10: `chg_irq` equals the flag ANDed with control bit 3 (interrupt enable).
- R11: When a clear write and a new mismatch occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register selection |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (triggers the snapshot on port reads) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Output latch toward the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pull_en | output | 8 | Per-pin weak pull-up enable |
| chg_irq | output | 1 | Change interrupt request |

## Verification
The bench drives a pin change so that the mismatch first appears in the same cycle as a snapshot read. A design that did not absorb that change would raise the flag anyway. It also lands a clear write in the cycle in which a fresh mismatch arrives, and samples `chg_irq` one edge later. A design where the clear wins would show the interrupt low for a cycle. Further checks show the following:

- Clears do nothing while a mismatch persists, which a design clearing unconditionally would fail.
- Lower pins and output pins never trip the flag, which a comparison over the whole port would fail.
- The single-bit update takes its other bits from the pins, which a design reusing the old latch would fail.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

    typedef enum logic [1:0] {
        REG_PORT = 2'd0,
        REG_DIR  = 2'd1,
        REG_CTRL = 2'd2,
        REG_PBIT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CHG_CLEAR  = 2'd0,
        CHG_ACTIVE = 2'd1,
        CHG_HELD   = 2'd2
    } chg_state_e;

    localparam int CTRL_PUD_BIT  = 7;
    localparam int CTRL_IE_BIT   = 3;
    localparam int CTRL_FLAG_BIT = 0;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= raw[b];
                stab_q <= meta_q;
            end
        end

        assign synced[b] = stab_q;
    end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_chg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   addr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] sync_pins,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] latch_q,
    output logic         pud_q,
    output logic         ie_q
);

    localparam int IDX_W = $clog2(W);

    logic [W-1:0] merged;

    always_comb begin
        merged = sync_pins;
        merged[wdata[IDX_W-1:0]] = wdata[IDX_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '1;
            latch_q <= '0;
            pud_q   <= 1'b1;
            ie_q    <= 1'b0;
        end else if (wr) begin
            unique case (reg_sel_e'(addr))
                REG_PORT: latch_q <= wdata;
                REG_DIR:  dir_q   <= wdata;
                REG_CTRL: begin
                    pud_q <= wdata[CTRL_PUD_BIT];
                    ie_q  <= wdata[CTRL_IE_BIT];
                end
                REG_PBIT: latch_q <= merged;
            endcase
        end
    end

endmodule

// File: rtl/gpio_chg_fsm.sv
module gpio_chg_fsm
    import gpio_chg_pkg::*;
#(
    parameter int W   = 8,
    parameter int LSB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     sync_pins,
    input  logic [W-1:0]     dir_q,
    input  logic             port_access,
    input  logic             clr_req,
    output logic [W-LSB-1:0] snap_q,
    output logic             mismatch,
    output logic             flag
);

    chg_state_e state_q, state_d;

    assign mismatch = |((sync_pins[W-1:LSB] ^ snap_q) & dir_q[W-1:LSB]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CHG_CLEAR;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (port_access) begin
                snap_q <= sync_pins[W-1:LSB];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CHG_CLEAR: begin
                if (!port_access && mismatch) state_d = CHG_ACTIVE;
            end
            CHG_ACTIVE: begin
                if (port_access || !mismatch) state_d = CHG_HELD;
            end
            CHG_HELD: begin
                if (port_access)   state_d = CHG_HELD;
                else if (mismatch) state_d = CHG_ACTIVE;
                else if (clr_req)  state_d = CHG_CLEAR;
            end
            default: state_d = CHG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q != CHG_CLEAR);
    end

endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
    import gpio_chg_pkg::*;
#(
    parameter int W       = 8,
    parameter int CHG_LSB = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_pull_en,
    output logic         chg_irq
);

    logic [W-1:0]         sync_pins;
    logic [W-1:0]         dir_q;
    logic [W-1:0]         latch_q;
    logic                 pud_q;
    logic                 ie_q;
    logic [W-CHG_LSB-1:0] snap_q;
    logic                 mismatch;
    logic                 flag;
    logic                 port_access;
    logic                 clr_req;
    logic [W-1:0]         ctrl_view;

    gpio_sync #(.W(W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .synced (sync_pins)
    );

    gpio_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .wdata     (bus_wdata),
        .sync_pins (sync_pins),
        .dir_q     (dir_q),
        .latch_q   (latch_q),
        .pud_q     (pud_q),
        .ie_q      (ie_q)
    );

    assign port_access = (bus_rd || bus_wr) &&
                         ((bus_addr == REG_PORT) || (bus_addr == REG_PBIT));
    assign clr_req     = bus_wr && (bus_addr == REG_CTRL) && !bus_wdata[CTRL_FLAG_BIT];

    gpio_chg_fsm #(.W(W), .LSB(CHG_LSB)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_pins   (sync_pins),
        .dir_q       (dir_q),
        .port_access (port_access),
        .clr_req     (clr_req),
        .snap_q      (snap_q),
        .mismatch    (mismatch),
        .flag        (flag)
    );

    always_comb begin
        ctrl_view                = '0;
        ctrl_view[CTRL_PUD_BIT]  = pud_q;
        ctrl_view[CTRL_IE_BIT]   = ie_q;
        ctrl_view[CTRL_FLAG_BIT] = flag;
    end

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            REG_PORT: bus_rdata = sync_pins;
            REG_DIR:  bus_rdata = dir_q;
            REG_CTRL: bus_rdata = ctrl_view;
            REG_PBIT: bus_rdata = sync_pins;
        endcase
    end

    assign pin_out     = latch_q;
    assign pin_oe      = ~dir_q;
    assign pin_pull_en = dir_q & {W{~pud_q}};
    assign chg_irq     = flag & ie_q;

endmodule

// File: rtl/gpio_chg_chk.sv
module gpio_chg_chk #(
    parameter int W   = 8,
    parameter int LSB = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic [W-1:0]     bus_wdata,
    input logic [W-1:0]     pin_out,
    input logic [W-1:0]     pin_oe,
    input logic [W-1:0]     pin_pull_en,
    input logic             chg_irq,
    input logic [W-1:0]     sync_pins,
    input logic [W-LSB-1:0] snap_q,
    input logic             mismatch,
    input logic             flag,
    input logic             port_access,
    input logic             clr_req
);

    AST_PULL_OFF_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pull_en & pin_oe) == '0); // R9

    AST_PORT_WRITE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> pin_out == $past(bus_wdata)); // R4

    AST_MISMATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && !port_access) |=> flag); // R6

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && clr_req && !port_access) |=> flag); // R11

    AST_SNAP_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        port_access |=> snap_q == $past(sync_pins[W-1:LSB])); // R8

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        chg_irq |-> flag); // R10

endmodule

bind gpio_chg_port gpio_chg_chk #(.W(W), .LSB(CHG_LSB)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .pin_pull_en (pin_pull_en),
    .chg_irq     (chg_irq),
    .sync_pins   (sync_pins),
    .snap_q      (snap_q),
    .mismatch    (mismatch),
    .flag        (flag),
    .port_access (port_access),
    .clr_req     (clr_req)
);

// File: tb/sim_gpio_chg_port.sv
`timescale 1ns/1ps
module sim_gpio_chg_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [7:0] pin_pull_en;
    logic       chg_irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] rd_val;

    always #5 clk = ~clk;

    gpio_chg_port u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pin_in      (pin_in),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .pin_pull_en (pin_pull_en),
        .chg_irq     (chg_irq)
    );

    // {pins, write addr, write data, expected pin_out, pin_oe, pin_pull_en}
    localparam logic [41:0] VEC [0:6] = '{
        {8'h00, 2'd1, 8'h0F, 8'h00, 8'hF0, 8'h00},
        {8'h11, 2'd0, 8'h96, 8'h96, 8'hF0, 8'h00},
        {8'h22, 2'd2, 8'h00, 8'h96, 8'hF0, 8'h0F},
        {8'h33, 2'd1, 8'hC3, 8'h96, 8'h3C, 8'hC3},
        {8'h44, 2'd0, 8'h00, 8'h00, 8'h3C, 8'hC3},
        {8'h55, 2'd2, 8'h80, 8'h00, 8'h3C, 8'h00},
        {8'h66, 2'd1, 8'hFF, 8'h00, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pin_in = 8'h00;
        idle(3);
        rst_n = 1'b1;
        idle(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset defaults
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pin_out", pin_out, 8'h00);
        check("R1 pin_pull_en", pin_pull_en, 8'h00);
        check("R1 irq", {7'd0, chg_irq}, 8'h00);
        bus_read(2'd1, rd_val); check("R1 dir", rd_val, 8'hFF);
        bus_read(2'd2, rd_val); check("R1 ctrl", rd_val, 8'h80);

        // Table: R2 R3 R4 R9
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            pin_in = VEC[i][41:34];
            bus_write(VEC[i][33:32], VEC[i][31:24]);
            idle(3);
            check("R2 pin_out", pin_out, VEC[i][23:16]);
            check("R2 pin_oe", pin_oe, VEC[i][15:8]);
            check("R9 pull_en", pin_pull_en, VEC[i][7:0]);
            bus_read(2'd0, rd_val);
            check("R3 port read", rd_val, VEC[i][41:34]);
        end

        // Change detection: R6 R7 R10
        do_reset();
        bus_read(2'd0, rd_val);
        pin_in = 8'h10;
        idle(4);
        bus_read(2'd2, rd_val); check("R6 flag set", rd_val, 8'h81);
        check("R10 irq masked", {7'd0, chg_irq}, 8'h00);
        bus_write(2'd2, 8'h88);
        bus_read(2'd2, rd_val); check("R7 clear ignored", rd_val, 8'h89);
        check("R10 irq on", {7'd0, chg_irq}, 8'h01);
        bus_read(2'd0, rd_val);
        bus_write(2'd2, 8'h88);
        bus_read(2'd2, rd_val); check("R7 clear after read", rd_val, 8'h88);
        check("R10 irq off", {7'd0, chg_irq}, 8'h00);

        pin_in = 8'h1F;
        idle(4);
        bus_read(2'd2, rd_val); check("R6 lower bits ignored", rd_val, 8'h88);
        bus_write(2'd1, 8'h7F);
        pin_in = 8'h9F;
        idle(4);
        bus_read(2'd2, rd_val); check("R6 output pin excluded", rd_val, 8'h88);
        bus_write(2'd1, 8'hFF);
        idle(2);
        bus_read(2'd2, rd_val); check("R6 input again", rd_val, 8'h89);
        bus_read(2'd0, rd_val);
        bus_write(2'd2, 8'h88);

        // R8 change absorbed by same-cycle snapshot
        @(negedge clk);
        pin_in = 8'h0F;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = 2'd0; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        idle(4);
        bus_read(2'd2, rd_val); check("R8 absorbed", rd_val, 8'h88);

        // R11 set wins over clear in the same cycle
        pin_in = 8'h8F;
        idle(4);
        bus_read(2'd0, rd_val);
        @(negedge clk);
        pin_in = 8'h0F;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = 2'd2; bus_wdata = 8'h88; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1 check("R11 set wins", {7'd0, chg_irq}, 8'h01);

        // R5 single-bit update built from pin levels
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h00);
        pin_in = 8'hA0;
        idle(4);
        bus_write(2'd3, 8'h09);
        check("R5 set bit1", pin_out, 8'hA2);
        bus_write(2'd3, 8'h07);
        check("R5 clear bit7", pin_out, 8'h20);
        check("R2 all outputs", pin_oe, 8'hFF);
        bus_read(2'd1, rd_val); check("R4 dir untouched", rd_val, 8'h00);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule